// File: doc/BRIEF.md
# Mesh Route Selector with Exception Table

This block computes the output port for a packet entering one router of a two-dimensional mesh whose grid may have holes. When a head flit arrives, the block compares the packet's destination coordinate with the router's own coordinate. It then picks one of five output ports: local, north, east, south or west. A run-time mode input selects the default rule. The first default is dimension-ordered routing, which corrects X first and then Y. The second default keeps the flit moving in the direction it was already travelling.

Some destinations sit behind a missing node or at the end of a dead-end corridor, and the default rule would send packets to them the wrong way. These destinations are listed in a small associative table of exceptions. The table is searched by destination. A matching entry supplies the port, and a miss leaves the decision to the default rule. Storage therefore grows with the number of exceptions and not with the size of the mesh. Table entries are loaded through a write port that takes an index.

The decision is registered and presented one cycle after the head flit. It stays fixed until the tail flit of the same packet has gone through.

Top module: `route_select`

## Requirements
- R1: After reset, `route_valid` is low and every table entry is invalid, so all destinations use the default rule.
- R2: Port codes are local=0, north=1, east=2, south=3, west=4. With `mode`=0, the route is east if the destination x is greater than the own x, and west if it is smaller. When the x values are equal, the route is north if the destination y is greater than the own y, and south if it is smaller.
- R3: With `mode`=1, the route is the arrival travel direction `flit_dir` when that code is 1 to 4. For any other arrival code (0 for local injection, or 5 to 7), the R2 rule applies.
- R4: A destination equal to the own coordinate routes to local (0), whatever the table holds and whichever mode is set.
- R5: If a valid table entry holds the destination, its stored 3-bit port is used in either mode. If no entry matches, the default rule of the current mode decides.
- R6: If several valid entries match the same destination, the entry with the lowest index wins.
- R7: When `cfg_we` is high at a clock edge, entry `cfg_idx` is written with `cfg_valid`, `cfg_x`, `cfg_y` and `cfg_port`. A head flit presented in a later cycle sees the new contents. Writing `cfg_valid`=0 removes the entry.
- R8: A head is accepted when `flit_valid` and `flit_head` are high and `route_valid` is low. At the next edge, `route_valid` rises and `route_port` carries the decision.
- R9: `route_port` holds steady while `route_valid` is high, and head flits arriving in that time are ignored. `route_valid` falls at the edge where `flit_valid` and `flit_tail` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mode | input | 1 | Default rule: 0 dimension-ordered, 1 keep direction |
| own_x | input | X_W | This router's x coordinate |
| own_y | input | Y_W | This router's y coordinate |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_valid | input | 1 | Valid bit for the written entry |
| cfg_x | input | X_W | Exception destination x |
| cfg_y | input | Y_W | Exception destination y |
| cfg_port | input | 3 | Port code for the exception |
| flit_valid | input | 1 | Flit present |
| flit_head | input | 1 | Flit is a head |
| flit_tail | input | 1 | Flit is a tail |
| flit_dx | input | X_W | Destination x carried by the head |
| flit_dy | input | Y_W | Destination y carried by the head |
| flit_dir | input | 3 | Travel direction of the arriving flit (port code) |
| route_valid | output | 1 | A decision is being held |
| route_port | output | 3 | Selected output port code |

## Verification
The assertions assume well-formed packet framing. Every packet opens with a head, a head is never also the tail, and the tail comes in a later cycle while the route is held. They also assume that `own_x` and `own_y` stay constant while a packet is in flight. The stimulus sends each packet as a head, then a chosen number of body flits, then a tail, followed by an idle cycle. Configuration writes happen only between packets, and the own coordinate is a fixed value for the whole run. One packet deliberately carries a stray head while its route is held, to show that the head is dropped.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam logic [2:0] P_LOCAL = 3'd0;
  localparam logic [2:0] P_NORTH = 3'd1;
  localparam logic [2:0] P_EAST  = 3'd2;
  localparam logic [2:0] P_SOUTH = 3'd3;
  localparam logic [2:0] P_WEST  = 3'd4;

  // true for the four mesh directions
  function automatic logic is_cardinal(input logic [2:0] code);
    return (code >= P_NORTH) && (code <= P_WEST);
  endfunction
endpackage

// File: rtl/route_dflt.sv
module route_dflt #(
  parameter int X_W = 3,
  parameter int Y_W = 3
) (
  input  logic           mode,
  input  logic [X_W-1:0] own_x,
  input  logic [Y_W-1:0] own_y,
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  input  logic [2:0]     in_dir,
  output logic [2:0]     port
);
  import route_pkg::*;

  function automatic logic [2:0] xy_port(
    input logic [X_W-1:0] ox, input logic [Y_W-1:0] oy,
    input logic [X_W-1:0] dx, input logic [Y_W-1:0] dy);
    if (dx > ox)      return P_EAST;
    else if (dx < ox) return P_WEST;
    else if (dy > oy) return P_NORTH;
    else if (dy < oy) return P_SOUTH;
    else              return P_LOCAL;
  endfunction

  logic [2:0] xy_res;
  assign xy_res = xy_port(own_x, own_y, dst_x, dst_y);

  always_comb begin
    if (mode && is_cardinal(in_dir)) port = in_dir;
    else                             port = xy_res;
  end
endmodule

// File: rtl/route_exc_table.sv
module route_exc_table #(
  parameter int N_ENT = 8,
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [X_W-1:0]   cfg_x,
  input  logic [Y_W-1:0]   cfg_y,
  input  logic [2:0]       cfg_port,
  input  logic [X_W-1:0]   look_x,
  input  logic [Y_W-1:0]   look_y,
  output logic             hit,
  output logic [2:0]       hit_port
);
  logic [N_ENT-1:0] ent_v;
  logic [X_W-1:0]   ent_x [N_ENT];
  logic [Y_W-1:0]   ent_y [N_ENT];
  logic [2:0]       ent_p [N_ENT];
  logic [N_ENT-1:0] match;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[i] <= 1'b0;
        ent_x[i] <= '0;
        ent_y[i] <= '0;
        ent_p[i] <= '0;
      end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
        ent_v[i] <= cfg_valid;
        ent_x[i] <= cfg_x;
        ent_y[i] <= cfg_y;
        ent_p[i] <= cfg_port;
      end
    end
    assign match[i] = ent_v[i] && (ent_x[i] == look_x) && (ent_y[i] == look_y);
  end

  // lowest index has priority: scan from the top down
  always_comb begin
    hit_port = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) hit_port = ent_p[i];
    end
  end
  assign hit = |match;
endmodule

// File: rtl/route_select.sv
module route_select #(
  parameter int N_ENT = 8,
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic [X_W-1:0]   own_x,
  input  logic [Y_W-1:0]   own_y,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [X_W-1:0]   cfg_x,
  input  logic [Y_W-1:0]   cfg_y,
  input  logic [2:0]       cfg_port,
  input  logic             flit_valid,
  input  logic             flit_head,
  input  logic             flit_tail,
  input  logic [X_W-1:0]   flit_dx,
  input  logic [Y_W-1:0]   flit_dy,
  input  logic [2:0]       flit_dir,
  output logic             route_valid,
  output logic [2:0]       route_port
);
  import route_pkg::*;

  logic       launch;
  logic       release_pkt;
  logic       dst_local;
  logic       tbl_hit;
  logic [2:0] tbl_port;
  logic [2:0] dflt_port;
  logic [2:0] next_port;

  route_dflt #(.X_W(X_W), .Y_W(Y_W)) u_dflt (
    .mode   (mode),
    .own_x  (own_x),
    .own_y  (own_y),
    .dst_x  (flit_dx),
    .dst_y  (flit_dy),
    .in_dir (flit_dir),
    .port   (dflt_port)
  );

  route_exc_table #(.N_ENT(N_ENT), .X_W(X_W), .Y_W(Y_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_valid (cfg_valid),
    .cfg_x     (cfg_x),
    .cfg_y     (cfg_y),
    .cfg_port  (cfg_port),
    .look_x    (flit_dx),
    .look_y    (flit_dy),
    .hit       (tbl_hit),
    .hit_port  (tbl_port)
  );

  assign dst_local   = (flit_dx == own_x) && (flit_dy == own_y);
  assign launch      = flit_valid && flit_head && !route_valid;
  assign release_pkt = flit_valid && flit_tail && route_valid;

  always_comb begin
    if (dst_local)    next_port = P_LOCAL;
    else if (tbl_hit) next_port = tbl_port;
    else              next_port = dflt_port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_valid <= 1'b0;
      route_port  <= P_LOCAL;
    end else if (launch) begin
      route_valid <= 1'b1;
      route_port  <= next_port;
    end else if (release_pkt) begin
      route_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/route_select_chk.sv
module route_select_chk #(
  parameter int X_W = 3,
  parameter int Y_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           launch,
  input logic           release_pkt,
  input logic           dst_local,
  input logic           tbl_hit,
  input logic [2:0]     tbl_port,
  input logic [2:0]     dflt_port,
  input logic           route_valid,
  input logic [2:0]     route_port
);
  AST_LAUNCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> route_valid); // R8
  AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && dst_local) |=> (route_port == 3'd0)); // R4
  AST_HIT_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !dst_local && tbl_hit) |=> (route_port == $past(tbl_port))); // R5
  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !dst_local && !tbl_hit) |=> (route_port == $past(dflt_port))); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && !release_pkt) |=> (route_valid && $stable(route_port))); // R9
  AST_TAIL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    release_pkt |=> !route_valid); // R9
endmodule

bind route_select route_select_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .launch      (launch),
  .release_pkt (release_pkt),
  .dst_local   (dst_local),
  .tbl_hit     (tbl_hit),
  .tbl_port    (tbl_port),
  .dflt_port   (dflt_port),
  .route_valid (route_valid),
  .route_port  (route_port)
);

// File: tb/route_select_tb.sv
`timescale 1ns/1ps
module route_select_tb;
  localparam int N_ENT = 8;
  localparam int X_W = 3;
  localparam int Y_W = 3;
  localparam int IDX_W = 3;
  localparam int OX = 3;
  localparam int OY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [X_W-1:0] own_x = X_W'(OX);
  logic [Y_W-1:0] own_y = Y_W'(OY);
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic cfg_valid = 1'b0;
  logic [X_W-1:0] cfg_x = '0;
  logic [Y_W-1:0] cfg_y = '0;
  logic [2:0] cfg_port = '0;
  logic flit_valid = 1'b0, flit_head = 1'b0, flit_tail = 1'b0;
  logic [X_W-1:0] flit_dx = '0;
  logic [Y_W-1:0] flit_dy = '0;
  logic [2:0] flit_dir = '0;
  logic route_valid;
  logic [2:0] route_port;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench copy of the table, written by the bench only
  bit     m_v [N_ENT];
  int     m_x [N_ENT];
  int     m_y [N_ENT];
  int     m_p [N_ENT];

  int     exp_q[$];
  string  tag_q[$];
  logic   prev_v = 1'b0;
  logic [2:0] held = '0;

  always #5 clk = ~clk;

  route_select #(.N_ENT(N_ENT), .X_W(X_W), .Y_W(Y_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .own_x(own_x), .own_y(own_y),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_port(cfg_port),
    .flit_valid(flit_valid), .flit_head(flit_head), .flit_tail(flit_tail),
    .flit_dx(flit_dx), .flit_dy(flit_dy), .flit_dir(flit_dir),
    .route_valid(route_valid), .route_port(route_port)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected route, written from the requirements
  function automatic int expect_port(input int dx, input int dy, input int dir);
    int sx, sy;
    if (dx == OX && dy == OY) return 0;            // R4
    for (int i = 0; i < N_ENT; i++)                // R5, R6
      if (m_v[i] && m_x[i] == dx && m_y[i] == dy) return m_p[i];
    if (mode && dir >= 1 && dir <= 4) return dir;  // R3
    sx = dx - OX;
    sy = dy - OY;                                  // R2
    if (sx != 0) return (sx > 0) ? 2 : 4;
    if (sy != 0) return (sy > 0) ? 1 : 3;
    return 0;
  endfunction

  task automatic write_entry(input int idx, input bit v, input int x, input int y, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v;
    cfg_x = X_W'(x); cfg_y = Y_W'(y); cfg_port = 3'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    m_v[idx] = v; m_x[idx] = x; m_y[idx] = y; m_p[idx] = p;
  endtask

  task automatic send_pkt(input string req, input int dx, input int dy, input int dir,
                          input int nbody, input bit stray_head);
    exp_q.push_back(expect_port(dx, dy, dir));
    tag_q.push_back(req);
    @(negedge clk);
    flit_valid = 1'b1; flit_head = 1'b1; flit_tail = 1'b0;
    flit_dx = X_W'(dx); flit_dy = Y_W'(dy); flit_dir = 3'(dir);
    @(negedge clk);
    check("R8 valid after head", int'(route_valid), 1);
    flit_head = 1'b0;
    for (int b = 0; b < nbody; b++) begin
      if (stray_head && b == 0) begin
        flit_head = 1'b1; flit_dx = X_W'(OX); flit_dy = Y_W'(OY); flit_dir = 3'd0;
      end else flit_head = 1'b0;
      @(negedge clk);
    end
    flit_head = 1'b0; flit_tail = 1'b1;
    @(negedge clk);
    check("R9 released after tail", int'(route_valid), 0);
    flit_valid = 1'b0; flit_tail = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard when a decision appears, watches hold
  always @(negedge clk) begin
    if (rst_n) begin
      if (route_valid && !prev_v) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected decision", 1, 0);
        end else begin
          check({tag_q.pop_front(), " port"}, int'(route_port), exp_q.pop_front());
        end
        held <= route_port;
      end else if (route_valid && prev_v) begin
        check("R9 port held", int'(route_port), int'(held));
      end
      prev_v <= route_valid;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_ENT; i++) begin m_v[i] = 0; m_x[i] = 0; m_y[i] = 0; m_p[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset valid low", int'(route_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(route_valid), 0);
    // R1: table empty, so defaults apply
    send_pkt("R1 R2 east", 6, 0, 0, 2, 0);
    send_pkt("R2 west", 0, 7, 0, 1, 0);
    send_pkt("R2 north", 3, 7, 0, 0, 0);
    send_pkt("R2 south", 3, 1, 0, 3, 0);
    send_pkt("R4 local", 3, 4, 0, 1, 0);
    // R7 write, R5 hit and miss
    write_entry(0, 1, 5, 5, 3);
    send_pkt("R5 R7 hit", 5, 5, 0, 1, 0);
    send_pkt("R5 miss", 5, 6, 0, 1, 0);
    // R6 lowest index wins
    write_entry(3, 1, 1, 2, 1);
    write_entry(1, 1, 1, 2, 2);
    send_pkt("R6 priority", 1, 2, 0, 2, 0);
    // R7 removal
    write_entry(1, 0, 1, 2, 2);
    send_pkt("R7 removed", 1, 2, 0, 1, 0);
    // R4 over table
    write_entry(5, 1, 3, 4, 4);
    send_pkt("R4 local over table", 3, 4, 0, 1, 0);
    // R3 keep-direction mode
    mode = 1'b1;
    send_pkt("R3 keep dir", 6, 6, 3, 1, 0);
    send_pkt("R3 injected uses xy", 6, 6, 0, 1, 0);
    send_pkt("R3 code 7 uses xy", 3, 0, 7, 1, 0);
    send_pkt("R5 hit in mode 1", 5, 5, 4, 1, 0);
    send_pkt("R4 local in mode 1", 3, 4, 2, 1, 0);
    mode = 1'b0;
    // R9 stray head ignored while held
    send_pkt("R9 stray head", 7, 1, 0, 3, 1);
    check("R8 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule